// File: doc/BRIEF.md
# Chroma Halfband Decimator and Cb/Cr Interleaver

This block turns a full-rate 4:4:4 component stream into 4:2:2. Each clock it takes one unsigned luma sample and one signed sample each of blue-difference (Cb) and red-difference (Cr) chroma. Both chroma channels run through a fixed 11-tap symmetric halfband low-pass filter. The filter's zero taps are those at even distance from the centre, and the centre tap has weight one half. The filtered chroma is rounded and clamped to the signed range -448..+448. The filter is evaluated every clock, but only every second result is kept.

The kept Cb and Cr results come from the same window, so they are co-sited. They are sent one after the other on a single chroma output: Cb first, and Cr on the following clock. A flag beside the chroma output tells which of the two is present. Luma is not decimated. It passes through a delay line whose length is a parameter, set by default so that luma lines up with the filter's centre tap.

An active-low synchronous sync input controls the decimation phase. While the registered sync is high, every output is held at zero and the flag is high. Once a low on sync has been registered, the next clock presents the first Cb. Sync must be brought low this way before valid data is streamed.

Top module: `chroma_hb_dec`

## Requirements
- R1: While rst_n is low, y_out and c_out are zero and c_is_cr is 1.
- R2: A high on sync_n is registered on each rising edge. On the edge after such a registration, y_out and c_out become zero and c_is_cr becomes 1.
- R3: The clock after the first registered low on sync_n presents a Cb sample. From then on, as long as sync_n stays low, Cb and Cr alternate on every clock.
- R4: c_is_cr encodes the content of c_out. The value 0 means c_out holds Cb and the value 1 means it holds Cr or the idle value.
- R5: A Cb output that appears after rising edge e equals the filter result for the 11 Cb samples taken at edges e-11 .. e-1. The result is computed as sum(h[k]*x) + 128, shifted right arithmetically by 8. The weights in 1/256 units, by distance from the centre sample (taken at edge e-6), are: 0→128, 1→75, 3→-14, 5→3, and 2, 4→0.
- R6: The filter result is saturated to the range -448..+448 before it is output.
- R7: A Cr output equals the filtered Cr from the same window as the Cb one clock before it, so Cr is co-sited with that Cb and delayed by one clock.
- R8: If sync_n returns high and later falls again, the outputs return to idle. The sequence then restarts with Cb on the clock after the new low is registered, whatever the previous phase was.
- R9: Outside idle, y_out after edge e equals y_in sampled at edge e-6 (LUMA_DLY). This keeps each Cb sample aligned with its luma.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low sync; its registered falling level starts the Cb/Cr phase |
| y_in | input | 10 | Unsigned luma sample |
| cb_in | input | 10 | Signed two's-complement Cb sample |
| cr_in | input | 10 | Signed two's-complement Cr sample |
| y_out | output | 10 | Delayed luma, zero while idle |
| c_out | output | 10 | Signed interleaved chroma, clamped to ±448 |
| c_is_cr | output | 1 | 0 = Cb on c_out, 1 = Cr or idle |

## Verification
The hardest state to reach is a re-sync: a rising then falling sync_n that arrives while the interleaver sits in its Cr phase. In that case the restart must override the phase and begin with Cb. The stimulus holds sync low for an odd number of clocks before raising it, so the next low lands on the opposite phase. It also repeats this with a later odd run. Saturation is reached only by holding both chroma inputs at a rail long enough to fill the window. Directed runs of constant extreme values do this, placed between the random stretches.

// File: rtl/chroma_hb_pkg.sv
package chroma_hb_pkg;
  localparam int CW   = 10;          // chroma sample width (signed)
  localparam int YW   = 10;          // luma sample width (unsigned)
  localparam int TAPS = 11;          // halfband kernel length
  localparam int CTR  = (TAPS - 1) / 2;
  localparam int AW   = 24;          // accumulator width
  localparam int SH   = 8;           // coefficient scale 2^SH
  localparam int LIM  = 448;         // chroma clamp magnitude

  localparam logic signed [AW-1:0] K0  = 128;
  localparam logic signed [AW-1:0] K1  = 75;
  localparam logic signed [AW-1:0] K3  = -14;
  localparam logic signed [AW-1:0] K5  = 3;
  localparam logic signed [AW-1:0] RND = 1 <<< (SH - 1);
  localparam logic signed [AW-1:0] LIM_HI = LIM;
  localparam logic signed [AW-1:0] LIM_LO = -LIM;

  // Weighted sum of the centre sample and three symmetric pair sums, rounded.
  function automatic logic signed [AW-1:0] hb_sum(
    input logic signed [CW-1:0] c,
    input logic signed [CW:0]   s1,
    input logic signed [CW:0]   s3,
    input logic signed [CW:0]   s5);
    logic signed [AW-1:0] acc;
    acc = AW'(c) * K0 + AW'(s1) * K1 + AW'(s3) * K3 + AW'(s5) * K5 + RND;
    return acc >>> SH;
  endfunction

  // Saturate a wide filter result to the chroma window.
  function automatic logic signed [CW-1:0] sat_c(input logic signed [AW-1:0] v);
    if (v > LIM_HI) return CW'(LIM);
    if (v < LIM_LO) return CW'(-LIM);
    return v[CW-1:0];
  endfunction
endpackage

// File: rtl/hb_chroma_filter.sv
module hb_chroma_filter
  import chroma_hb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW-1:0] din,
  output logic signed [CW-1:0] fout
);
  logic signed [CW-1:0] tap [TAPS];
  logic signed [CW:0]   s1, s3, s5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) tap[i] <= '0;
    end else begin
      tap[0] <= din;
      for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
    end
  end

  always_comb begin
    s1 = (CW+1)'(tap[CTR-1]) + (CW+1)'(tap[CTR+1]);
    s3 = (CW+1)'(tap[CTR-3]) + (CW+1)'(tap[CTR+3]);
    s5 = (CW+1)'(tap[CTR-5]) + (CW+1)'(tap[CTR+5]);
    fout = sat_c(hb_sum(tap[CTR], s1, s3, s5));
  end
endmodule

// File: rtl/luma_delay_line.sv
module luma_delay_line
  import chroma_hb_pkg::*;
#(
  parameter int DLY = CTR + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic [YW-1:0] din,
  output logic [YW-1:0] dout
);
  logic [YW-1:0] stg [DLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) stg[i] <= '0;
      dout <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DLY; i++) stg[i] <= stg[i-1];
      dout <= idle ? '0 : stg[DLY-1];
    end
  end
endmodule

// File: rtl/cbcr_interleave.sv
module cbcr_interleave
  import chroma_hb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_n,
  input  logic signed [CW-1:0] cb_f,
  input  logic signed [CW-1:0] cr_f,
  output logic                 sync_q,
  output logic signed [CW-1:0] c_out,
  output logic                 c_is_cr
);
  logic                 ph;
  logic signed [CW-1:0] cr_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b1;
      ph      <= 1'b0;
      c_out   <= '0;
      c_is_cr <= 1'b1;
      cr_hold <= '0;
    end else begin
      sync_q <= sync_n;
      if (sync_q) begin
        ph      <= 1'b0;
        c_out   <= '0;
        c_is_cr <= 1'b1;
      end else if (!ph) begin
        ph      <= 1'b1;
        c_out   <= cb_f;
        c_is_cr <= 1'b0;
        cr_hold <= cr_f;
      end else begin
        ph      <= 1'b0;
        c_out   <= cr_hold;
        c_is_cr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/chroma_hb_dec.sv
module chroma_hb_dec
  import chroma_hb_pkg::*;
#(
  parameter int LUMA_DLY = CTR + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_n,
  input  logic [YW-1:0]        y_in,
  input  logic signed [CW-1:0] cb_in,
  input  logic signed [CW-1:0] cr_in,
  output logic [YW-1:0]        y_out,
  output logic signed [CW-1:0] c_out,
  output logic                 c_is_cr
);
  logic signed [CW-1:0] cb_f, cr_f;
  logic                 sync_q;

  hb_chroma_filter u_cb_filt (.clk(clk), .rst_n(rst_n), .din(cb_in), .fout(cb_f));
  hb_chroma_filter u_cr_filt (.clk(clk), .rst_n(rst_n), .din(cr_in), .fout(cr_f));

  cbcr_interleave u_mux (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .cb_f(cb_f), .cr_f(cr_f),
    .sync_q(sync_q), .c_out(c_out), .c_is_cr(c_is_cr));

  luma_delay_line #(.DLY(LUMA_DLY)) u_luma (
    .clk(clk), .rst_n(rst_n), .idle(sync_q), .din(y_in), .dout(y_out));
endmodule

// File: rtl/chroma_hb_dec_chk.sv
module chroma_hb_dec_chk
  import chroma_hb_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync_q,
  input logic [YW-1:0]        y_out,
  input logic signed [CW-1:0] c_out,
  input logic                 c_is_cr
);
  localparam logic signed [CW-1:0] CHI = CW'(LIM);
  localparam logic signed [CW-1:0] CLO = CW'(-LIM);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> (c_out == '0 && y_out == '0 && c_is_cr)); // R2
  AST_CB_THEN_CR: assert property (@(posedge clk) disable iff (!rst_n)
    !c_is_cr |=> c_is_cr); // R3
  AST_FIRST_CB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) |=> !c_is_cr); // R8
  AST_CHROMA_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out <= CHI && c_out >= CLO)); // R6
endmodule

bind chroma_hb_dec chroma_hb_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_q(sync_q),
  .y_out(y_out), .c_out(c_out), .c_is_cr(c_is_cr));

// File: tb/chroma_hb_dec_bench.sv
module chroma_hb_dec_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic [9:0] y_in = '0;
  logic signed [9:0] cb_in = '0, cr_in = '0;
  logic [9:0] y_out;
  logic signed [9:0] c_out;
  logic c_is_cr;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model state
  int mcb [11], mcr [11], my [6];
  bit msq = 1, mph = 0;
  int mcrh = 0, falls = 0;
  int ey = 0, ec = 0, ef = 1;
  string tc = "R1", tf = "R1", ty = "R1";

  chroma_hb_dec u_chroma_hb_dec (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .y_in(y_in),
    .cb_in(cb_in), .cr_in(cr_in), .y_out(y_out), .c_out(c_out), .c_is_cr(c_is_cr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int coef(int k);
    int d = (k > 5) ? k - 5 : 5 - k;
    case (d)
      0: return 128;
      1: return 75;
      3: return -14;
      5: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int bfilt(int w [11], output bit sat);
    int acc = 0, v;
    for (int k = 0; k < 11; k++) acc += coef(k) * w[k];
    v = (acc + 128) >>> 8;
    sat = (v > 448) || (v < -448);
    if (v > 448) v = 448;
    if (v < -448) v = -448;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // At a falling edge: compare outputs, drive new inputs, advance model.
  task automatic cyc(int cb, int cr, int y, bit s);
    bit sat;
    @(negedge clk);
    check({tc, " c_out"}, int'(c_out), ec);
    check({tf, " c_is_cr"}, int'(c_is_cr), ef);
    check({ty, " y_out"}, int'(y_out), ey);
    cb_in = 10'(cb); cr_in = 10'(cr); y_in = 10'(y); sync_n = s;
    if (msq) begin
      ec = 0; ef = 1; ey = 0; mph = 0;
      tc = "R2"; tf = "R2"; ty = "R2";
    end else if (!mph) begin
      ec = bfilt(mcb, sat);
      tc = sat ? "R6" : "R5";
      mcrh = bfilt(mcr, sat);
      ef = 0; tf = (falls > 1) ? "R8 R3 R4" : "R3 R4";
      ey = my[5]; ty = "R9"; mph = 1;
    end else begin
      ec = mcrh; tc = "R7"; ef = 1; tf = "R3 R4";
      ey = my[5]; ty = "R9"; mph = 0;
    end
    for (int i = 10; i > 0; i--) begin mcb[i] = mcb[i-1]; mcr[i] = mcr[i-1]; end
    for (int i = 5; i > 0; i--) my[i] = my[i-1];
    mcb[0] = cb; mcr[0] = cr; my[0] = y;
    if (msq && !s) falls++;
    msq = s;
  endtask

  task automatic rnd(int n, bit s);
    for (int i = 0; i < n; i++)
      cyc(int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512,
          int'($urandom_range(0, 1023)), s);
  endtask

  initial begin
    void'($urandom(32'd20250));
    for (int i = 0; i < 11; i++) begin mcb[i] = 0; mcr[i] = 0; end
    for (int i = 0; i < 6; i++) my[i] = 0;
    repeat (3) begin
      @(negedge clk);
      check("R1 c_out", int'(c_out), 0);
      check("R1 c_is_cr", int'(c_is_cr), 1);
      check("R1 y_out", int'(y_out), 0);
    end
    rst_n = 1'b1;
    rnd(12, 1'b1);                    // idle with live data (R2)
    rnd(200, 1'b0);                   // main random run (R3 R5 R7 R9)
    repeat (20) cyc(511, -512, 1023, 1'b0);   // rail saturation (R6)
    repeat (20) cyc(-512, 511, 0, 1'b0);
    repeat (16) cyc(0, 0, 5, 1'b0);
    cyc(200, -200, 7, 1'b0);          // impulse shows the kernel shape (R5)
    repeat (14) cyc(0, 0, 9, 1'b0);
    rnd(3, 1'b1);                     // re-sync from odd phase (R8)
    rnd(101, 1'b0);
    rnd(4, 1'b1);
    rnd(57, 1'b0);
    rnd(2, 1'b1);
    rnd(40, 1'b0);
    cyc(0, 0, 0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule